// File: doc/BRIEF.md
# Alternate-Phase Dual-Channel Sample Capture

This block is the digital front end of a two-channel converter whose channels share a single data bus. Channel A takes its word from the bus on the rising clock edge and channel B on the falling edge. A host can therefore interleave two sample streams on one set of wires and run at one word per clock half-period. Each channel holds the word it took in a capture stage. The next qualifying edge of that channel's own polarity moves it into an output code register. The two codes thus change on opposite clock phases and never together.

An active-low select gates the block as a whole. While it is high, the bus is ignored and neither stage moves. A run qualifier from the power controller can freeze the output codes, for standby, while the capture stages keep following the bus. A per-channel valid flag shows that the code register holds a word that really came from the bus since the last reset. Reset is synchronous and active high. Each channel acts on it at its own edge.

Top module: `dual_phase_capture`

## Requirements
- R1: While `rst` is high at a channel's edge (rising for A, falling for B), that channel's capture stage, code and valid flag are all cleared to zero.
- R2: When `cs_n` is low at a rising edge, channel A captures `din`. The captured word appears on `code_a` (bit 0 least significant) just after the next rising edge at which `cs_n` is low and `run` is high. A continuous stream with select low and run high shows each word on `code_a` one clock after it was presented, in order.
- R3: Channel B behaves as R2 but uses falling edges, so each word shows on `code_b` one clock after the falling edge that captured it.
- R4: When `cs_n` is high at a channel's edge, that channel's capture stage and code register keep their values and `din` is ignored.
- R5: When `run` is low at a channel's edge, the code register holds. If `cs_n` is low at that edge, the capture stage still takes the new word, replacing the older one. The next enabled transfer delivers the newest captured word.
- R6: `code_a` and `valid_a` change only at rising edges. `code_b` and `valid_b` change only at falling edges.
- R7: A valid flag rises at the first transfer of a word captured since reset. It stays high until reset. While a valid flag is low, its code is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; A uses the rising edge, B the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high ignores the bus and freezes both stages |
| din | input | W (10) | Shared data bus, bit 0 least significant |
| run | input | 1 | High lets captured words move to the code registers |
| code_a | output | W (10) | Channel A output code |
| code_b | output | W (10) | Channel B output code |
| valid_a | output | 1 | Channel A code holds a captured word |
| valid_b | output | 1 | Channel B code holds a captured word |

## Verification
Both edges sample the same bus, so the properties assume that `din`, `cs_n`, `run` and `rst` never change close to either edge. They also assume that reset lasts across at least one rising and one falling edge. The stimulus changes every input 5 ns after an edge, which is a quarter period away from the next edge of either kind. Reset is applied on the half-period before a rising edge and held through the falling edge that follows it. Separate bus words are driven before each rising and each falling edge, so the two channels carry different streams. This exposes any mix-up of edges or channels.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;
  localparam int DPC_CHANNELS = 2;
endpackage

// File: rtl/dpc_capture_stage.sv
module dpc_capture_stage #(
  parameter int             W    = 10,
  parameter dpc_pkg::edge_e EDGE = dpc_pkg::EDGE_RISE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] held,
  output logic         full
);
  logic [W-1:0] held_d;
  logic         full_d;

  always_comb begin
    held_d = held;
    full_d = full;
    if (rst) begin
      held_d = '0;
      full_d = 1'b0;
    end else if (!cs_n) begin
      held_d = din;
      full_d = 1'b1;
    end
  end

  generate
    if (EDGE == dpc_pkg::EDGE_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        held <= held_d;
        full <= full_d;
      end
    end else begin : g_fall
      always_ff @(negedge clk) begin
        held <= held_d;
        full <= full_d;
      end
    end
  endgenerate
endmodule

// File: rtl/dpc_convert_stage.sv
module dpc_convert_stage #(
  parameter int             W    = 10,
  parameter dpc_pkg::edge_e EDGE = dpc_pkg::EDGE_RISE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         run,
  input  logic [W-1:0] held,
  input  logic         full,
  output logic [W-1:0] code,
  output logic         valid
);
  logic         move;
  logic [W-1:0] code_d;
  logic         valid_d;

  assign move = !cs_n && run;

  always_comb begin
    code_d  = code;
    valid_d = valid;
    if (rst) begin
      code_d  = '0;
      valid_d = 1'b0;
    end else if (move) begin
      code_d = held;
      if (full) valid_d = 1'b1;
    end
  end

  generate
    if (EDGE == dpc_pkg::EDGE_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        code  <= code_d;
        valid <= valid_d;
      end
    end else begin : g_fall
      always_ff @(negedge clk) begin
        code  <= code_d;
        valid <= valid_d;
      end
    end
  endgenerate
endmodule

// File: rtl/dual_phase_capture.sv
module dual_phase_capture #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic [W-1:0] din,
  input  logic         run,
  output logic [W-1:0] code_a,
  output logic [W-1:0] code_b,
  output logic         valid_a,
  output logic         valid_b
);
  localparam int NCH = dpc_pkg::DPC_CHANNELS;

  logic [NCH-1:0][W-1:0] held_w;
  logic [NCH-1:0]        full_w;
  logic [NCH-1:0][W-1:0] code_w;
  logic [NCH-1:0]        valid_w;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    localparam dpc_pkg::edge_e LANE_EDGE =
      (ch == 0) ? dpc_pkg::EDGE_RISE : dpc_pkg::EDGE_FALL;

    dpc_capture_stage #(.W(W), .EDGE(LANE_EDGE)) u_cap (
      .clk  (clk),
      .rst  (rst),
      .cs_n (cs_n),
      .din  (din),
      .held (held_w[ch]),
      .full (full_w[ch])
    );

    dpc_convert_stage #(.W(W), .EDGE(LANE_EDGE)) u_cnv (
      .clk   (clk),
      .rst   (rst),
      .cs_n  (cs_n),
      .run   (run),
      .held  (held_w[ch]),
      .full  (full_w[ch]),
      .code  (code_w[ch]),
      .valid (valid_w[ch])
    );
  end

  assign code_a  = code_w[0];
  assign code_b  = code_w[1];
  assign valid_a = valid_w[0];
  assign valid_b = valid_w[1];
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_n,
  input logic [W-1:0] din,
  input logic         run,
  input logic [W-1:0] code_a,
  input logic [W-1:0] code_b,
  input logic         valid_a,
  input logic         valid_b
);
  logic [1:0]   rise_age = 2'd0;
  logic [1:0]   fall_age = 2'd0;
  logic         seen_rise = 1'b0;
  logic         seen_fall = 1'b0;
  logic [W-1:0] b_at_rise = '0;
  logic [W-1:0] a_at_fall = '0;
  logic         vb_at_rise = 1'b0;
  logic         va_at_fall = 1'b0;

  always_ff @(posedge clk) begin
    rise_age   <= rst ? 2'd0 : ((rise_age == 2'd3) ? rise_age : rise_age + 2'd1);
    seen_rise  <= !rst;
    b_at_rise  <= code_b;
    vb_at_rise <= valid_b;
  end

  always_ff @(negedge clk) begin
    fall_age   <= rst ? 2'd0 : ((fall_age == 2'd3) ? fall_age : fall_age + 2'd1);
    seen_fall  <= !rst;
    a_at_fall  <= code_a;
    va_at_fall <= valid_a;
  end

  // R6: a rising edge leaves channel B untouched, a falling edge leaves A untouched
  p_b_quiet_at_rise_r6: assert property (@(negedge clk) disable iff (rst)
    seen_rise |-> (code_b == b_at_rise && valid_b == vb_at_rise));
  p_a_quiet_at_fall_r6: assert property (@(posedge clk) disable iff (rst)
    seen_fall |-> (code_a == a_at_fall && valid_a == va_at_fall));

  p_a_cs_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rise_age >= 2'd1 && cs_n) |=> $stable(code_a));
  p_b_cs_hold_r4: assert property (@(negedge clk) disable iff (rst)
    (fall_age >= 2'd1 && cs_n) |=> $stable(code_b));

  p_a_run_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (rise_age >= 2'd1 && !run) |=> $stable(code_a));
  p_b_run_hold_r5: assert property (@(negedge clk) disable iff (rst)
    (fall_age >= 2'd1 && !run) |=> $stable(code_b));

  p_a_pipe_r2: assert property (@(posedge clk) disable iff (rst)
    (rise_age >= 2'd1 && !cs_n) ##1 (!cs_n && run) |=> code_a == $past(din, 2));
  p_b_pipe_r3: assert property (@(negedge clk) disable iff (rst)
    (fall_age >= 2'd1 && !cs_n) ##1 (!cs_n && run) |=> code_b == $past(din, 2));

  p_a_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    valid_a |=> valid_a);
  p_b_valid_sticky_r7: assert property (@(negedge clk) disable iff (rst)
    valid_b |=> valid_b);
  p_a_zero_invalid_r7: assert property (@(posedge clk) disable iff (rst)
    (rise_age >= 2'd1 && !valid_a) |-> code_a == '0);
  p_b_zero_invalid_r7: assert property (@(negedge clk) disable iff (rst)
    (fall_age >= 2'd1 && !valid_b) |-> code_b == '0);
endmodule

bind dual_phase_capture dpc_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .din     (din),
  .run     (run),
  .code_a  (code_a),
  .code_b  (code_b),
  .valid_a (valid_a),
  .valid_b (valid_b)
);

// File: tb/dual_phase_capture_tb.sv
module dual_phase_capture_tb;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic [W-1:0] din = '0;
  logic         run = 1'b0;
  logic [W-1:0] code_a, code_b;
  logic         valid_a, valid_b;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int word_ctr = 0;

  string lab_a = "R1";
  string lab_b = "R1";

  // behavioural reference state
  logic [W-1:0] q_a[$];
  logic [W-1:0] q_b[$];
  logic [W-1:0] exp_a = '0, exp_b = '0;
  bit           ev_a = 0, ev_b = 0;
  logic [W-1:0] a_seen, b_seen;
  bit           a_seen_ok = 0, b_seen_ok = 0;

  dual_phase_capture #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .din(din), .run(run),
    .code_a(code_a), .code_b(code_b), .valid_a(valid_a), .valid_b(valid_b)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      exp_a = '0; ev_a = 0; q_a.delete();
    end else begin
      if (!cs_n && run && q_a.size() > 0) begin exp_a = q_a[0]; ev_a = 1; end
      if (!cs_n) begin q_a.delete(); q_a.push_back(din); end
    end
    #2;
    if (!done) begin
      chk(lab_a, "code_a", int'(code_a), int'(exp_a));
      chk("R7", "valid_a", int'(valid_a), int'(ev_a));
      if (b_seen_ok) chk("R6", "code_b moved on rising edge", int'(code_b), int'(b_seen));
      a_seen = code_a; a_seen_ok = 1;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      exp_b = '0; ev_b = 0; q_b.delete();
    end else begin
      if (!cs_n && run && q_b.size() > 0) begin exp_b = q_b[0]; ev_b = 1; end
      if (!cs_n) begin q_b.delete(); q_b.push_back(din); end
    end
    #2;
    if (!done) begin
      chk(lab_b, "code_b", int'(code_b), int'(exp_b));
      chk("R7", "valid_b", int'(valid_b), int'(ev_b));
      if (a_seen_ok) chk("R6", "code_a moved on falling edge", int'(code_a), int'(a_seen));
      b_seen = code_b; b_seen_ok = 1;
    end
  end

  function automatic logic [W-1:0] next_word();
    word_ctr++;
    return W'((word_ctr * 389 + 17) ^ (word_ctr << 3));
  endfunction

  // set inputs seen by the coming rising edge
  task automatic to_rise(input logic r, input logic c, input logic ru, input logic [W-1:0] d);
    @(negedge clk); #5;
    rst = r; cs_n = c; run = ru; din = d;
  endtask

  // set inputs seen by the coming falling edge
  task automatic to_fall(input logic c, input logic ru, input logic [W-1:0] d);
    @(posedge clk); #5;
    cs_n = c; run = ru; din = d;
  endtask

  task automatic cyc(input logic r, input logic ca, input logic ra, input logic cb, input logic rb);
    to_rise(r, ca, ra, next_word());
    to_fall(cb, rb, next_word());
  endtask

  initial begin
    // R1: reset state
    lab_a = "R1"; lab_b = "R1";
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 1, 0);
    // R7 first transfers then R2/R3 streaming
    lab_a = "R7"; lab_b = "R7";
    cyc(0, 0, 1, 0, 1);
    lab_a = "R2"; lab_b = "R3";
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0, 1);
    // R4: select high on alternate edges
    lab_a = "R4"; lab_b = "R4";
    for (int i = 0; i < 30; i++) cyc(0, (i % 3) == 0, 1, (i % 4) == 1, 1);
    // R5: run low with select low, then release
    lab_a = "R5"; lab_b = "R5";
    for (int i = 0; i < 30; i++) cyc(0, 0, (i % 5) > 2, 0, (i % 4) == 0);
    // R1: reset mid-stream, then R7 restart with select high first
    lab_a = "R1"; lab_b = "R1";
    cyc(1, 0, 1, 0, 1);
    cyc(1, 0, 1, 0, 1);
    lab_a = "R7"; lab_b = "R7";
    cyc(0, 1, 1, 1, 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 1, 1);
    cyc(0, 0, 1, 0, 1);
    lab_a = "R2"; lab_b = "R3";
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, 0, 1);
    @(posedge clk); #8;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule